// File: doc/BRIEF.md
# Extended Integer Execute Unit

This unit decodes and executes a group of 64-bit integer operations that share one major opcode (`011100`, instruction bits [31:26]). It is purely combinational. A 32-bit instruction word and the two source register values go in. Out comes a flag saying the word was recognised, the index of the register to be written, a write enable and the 64-bit result. The surrounding core supplies the operand values read from its register file and performs the write-back.

The group covers the following operations:
- an 8-bit wrapping add;
- the low half of a 64x64 multiply;
- a sign-extending bit-field extract;
- a zero-filled bit-field insert;
- a 32- or 64-bit population count;
- equal / not-equal tests against a register or a sign-extended 10-bit immediate.

The bit-field position is six bits wide. Its top bit lives in instruction bit 0, away from the other five, so one encoding pattern serves both the low and the upper-half variants.

Top module: `xiu_exec`

## Requirements
- R1: A word is recognised (valid high) only when bits [31:26] equal `011100` and the low bits match one of the encodings in R2, R3, R5, R6, R7, R8 and R9. Any other major opcode gives valid low.
- R2: Byte add: bits [10:6]=0 and bits [5:0]=`101000`. The result is the low 8 bits of src_a+src_b, zero-extended. The destination is bits [15:11].
- R3: Multiply: bits [10:6]=0 and bits [5:0]=`000011`. The result is the low 64 bits of src_a*src_b. The destination is bits [15:11].
- R4: Bit-field forms take length-minus-one from bits [15:11] and position p={bit 0, bits [10:6]}. Their destination is bits [20:16].
- R5: Extract (bits [5:1]=`11101`) takes lenm1+1 bits of src_a starting at bit p and sign-extends them to 64 bits.
- R6: Insert (bits [5:1]=`11001`) places the low lenm1+1 bits of src_a at bit p. All other bits are zero.
- R7: Population count: bits [20:16]=0, bits [10:6]=0 and bits [5:1]=`10110`. It counts the ones of src_a[31:0] when bit 0 is 0 and of all 64 bits when bit 0 is 1. The destination is bits [15:11].
- R8: Register compare: bits [10:6]=0 and bits [5:1]=`10101`. It yields 1 when src_a==src_b (bit 0 = 0) or when src_a!=src_b (bit 0 = 1), and 0 otherwise. The destination is bits [15:11].
- R9: Immediate compare (bits [5:1]=`10111`) tests src_a against bits [15:6] sign-extended to 64 bits. Bit 0 selects equal (0) or not-equal (1), the result is 0 or 1, and the destination is bits [20:16].
- R10: A recognised word whose destination index is 0 drives write enable low. A nonzero destination drives it high.
- R11: When p+lenm1+1 exceeds 64, insert drops the field bits that fall past bit 63. Extract takes its sign from src_a[63].
- R12: An unrecognised word drives valid and write enable low and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 64 | Value of the register named by bits [25:21] |
| src_b_i | input | 64 | Value of the register named by bits [20:16] |
| valid_o | output | 1 | Word belongs to this group |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write the result back |
| result_o | output | 64 | Operation result |

## Verification
All outputs are combinational, so every result is due in the same cycle its instruction word and operands are applied, with no register in the path. The bench changes inputs just after a rising edge and samples the outputs at the following falling edge. Each operand set therefore has half a period to settle, and no check depends on process ordering at an edge. Expected values come from bit-by-bit loop models in the bench, kept apart from the shift-and-mask datapaths of the design.

// File: rtl/xiu_pkg.sv
package xiu_pkg;
  localparam int XLEN   = 64;
  localparam int REGW   = 5;
  localparam int POSW   = $clog2(XLEN);
  localparam int CNTW   = $clog2(XLEN + 1);
  localparam int IMMW   = 10;

  localparam logic [5:0] MAJOR_OPC = 6'b011100;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_BADD,
    OP_MUL,
    OP_EXTS,
    OP_CINS,
    OP_POP,
    OP_CMPR,
    OP_CMPI
  } xiu_op_e;

  typedef struct packed {
    xiu_op_e             op;
    logic [REGW-1:0]     dest;
    logic [POSW-1:0]     pos;
    logic [4:0]          lenm1;
    logic                alt;
    logic [XLEN-1:0]     imm;
  } xiu_dec_t;
endpackage

// File: rtl/xiu_decode.sv
module xiu_decode
  import xiu_pkg::*;
(
  input  logic [31:0] instr_i,
  output xiu_dec_t    dec_o
);
  logic [5:0] major;
  logic [4:0] f_rt, f_rd, f_sa, f_sub;
  logic       f_low;
  logic [IMMW-1:0] f_imm;
  logic       unused_rs;

  assign major     = instr_i[31:26];
  assign f_rt      = instr_i[20:16];
  assign f_rd      = instr_i[15:11];
  assign f_sa      = instr_i[10:6];
  assign f_sub     = instr_i[5:1];
  assign f_low     = instr_i[0];
  assign f_imm     = instr_i[15:6];
  assign unused_rs = ^instr_i[25:21];

  always_comb begin
    dec_o       = '0;
    dec_o.op    = OP_NONE;
    dec_o.pos   = {f_low, f_sa};
    dec_o.lenm1 = f_rd;
    dec_o.alt   = f_low;
    dec_o.imm   = {{(XLEN-IMMW){f_imm[IMMW-1]}}, f_imm};
    if (major == MAJOR_OPC) begin
      if (f_sa == 5'd0 && {f_sub, f_low} == 6'b101000) begin
        dec_o.op   = OP_BADD;
        dec_o.dest = f_rd;
      end else if (f_sa == 5'd0 && {f_sub, f_low} == 6'b000011) begin
        dec_o.op   = OP_MUL;
        dec_o.dest = f_rd;
      end else if (f_sub == 5'b11101) begin
        dec_o.op   = OP_EXTS;
        dec_o.dest = f_rt;
      end else if (f_sub == 5'b11001) begin
        dec_o.op   = OP_CINS;
        dec_o.dest = f_rt;
      end else if (f_sub == 5'b10110 && f_sa == 5'd0 && f_rt == 5'd0) begin
        dec_o.op   = OP_POP;
        dec_o.dest = f_rd;
      end else if (f_sub == 5'b10101 && f_sa == 5'd0) begin
        dec_o.op   = OP_CMPR;
        dec_o.dest = f_rd;
      end else if (f_sub == 5'b10111) begin
        dec_o.op   = OP_CMPI;
        dec_o.dest = f_rt;
      end
    end
  end
endmodule

// File: rtl/xiu_bitfield.sv
module xiu_bitfield #(
  parameter int WIDTH = 64,
  parameter int LENW  = 5
) (
  input  logic [WIDTH-1:0]         src_i,
  input  logic [$clog2(WIDTH)-1:0] pos_i,
  input  logic [LENW-1:0]          lenm1_i,
  output logic [WIDTH-1:0]         ext_o,
  output logic [WIDTH-1:0]         ins_o
);
  localparam int PW = $clog2(WIDTH);
  localparam logic [PW:0] TOP_BIT = (PW+1)'(WIDTH - 1);

  logic [PW:0]       hi_raw;
  logic [PW-1:0]     hi_bit;
  logic [PW-1:0]     span;
  logic              sign_bit;
  logic [WIDTH-1:0]  shifted;
  logic [WIDTH-1:0]  ext_mask;
  logic [WIDTH-1:0]  ins_mask;

  // Highest source bit the field may reach, clamped to the word.
  assign hi_raw   = {1'b0, pos_i} + (PW+1)'(lenm1_i);
  assign hi_bit   = (hi_raw > TOP_BIT) ? TOP_BIT[PW-1:0] : hi_raw[PW-1:0];
  assign span     = hi_bit - pos_i;
  assign sign_bit = src_i[hi_bit];
  assign shifted  = src_i >> pos_i;
  assign ext_mask = (WIDTH'(2) << span) - WIDTH'(1);
  assign ext_o    = (shifted & ext_mask) | (sign_bit ? ~ext_mask : '0);

  assign ins_mask = (WIDTH'(2) << lenm1_i) - WIDTH'(1);
  assign ins_o    = (src_i & ins_mask) << pos_i;
endmodule

// File: rtl/xiu_popcnt.sv
module xiu_popcnt #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]               vec_i,
  output logic [$clog2(WIDTH+1)-1:0]     cnt_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam int HALF = WIDTH / 2;

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_comb begin
    lo_cnt = '0;
    hi_cnt = '0;
    for (int i = 0; i < HALF; i++) begin
      lo_cnt = lo_cnt + CW'(vec_i[i]);
      hi_cnt = hi_cnt + CW'(vec_i[i + HALF]);
    end
  end

  assign cnt_o = lo_cnt + hi_cnt;
endmodule

// File: rtl/xiu_exec.sv
module xiu_exec
  import xiu_pkg::*;
(
  input  logic [31:0]   instr_i,
  input  logic [63:0]   src_a_i,
  input  logic [63:0]   src_b_i,
  output logic          valid_o,
  output logic [4:0]    dest_o,
  output logic          wr_en_o,
  output logic [63:0]   result_o
);
  xiu_dec_t         dec;
  logic [XLEN-1:0]  ext_val, ins_val, prod, pop_src;
  logic [7:0]       byte_sum;
  logic [CNTW-1:0]  pop_cnt;
  logic             reg_eq, imm_eq;

  xiu_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  xiu_bitfield #(.WIDTH(XLEN), .LENW(5)) u_bf (
    .src_i   (src_a_i),
    .pos_i   (dec.pos),
    .lenm1_i (dec.lenm1),
    .ext_o   (ext_val),
    .ins_o   (ins_val)
  );

  assign pop_src = dec.alt ? src_a_i : {{(XLEN/2){1'b0}}, src_a_i[XLEN/2-1:0]};

  xiu_popcnt #(.WIDTH(XLEN)) u_pop (
    .vec_i (pop_src),
    .cnt_o (pop_cnt)
  );

  assign byte_sum = src_a_i[7:0] + src_b_i[7:0];
  assign prod     = src_a_i * src_b_i;
  assign reg_eq   = (src_a_i == src_b_i);
  assign imm_eq   = (src_a_i == dec.imm);

  always_comb begin
    result_o = '0;
    unique case (dec.op)
      OP_BADD: result_o = {{(XLEN-8){1'b0}}, byte_sum};
      OP_MUL:  result_o = prod;
      OP_EXTS: result_o = ext_val;
      OP_CINS: result_o = ins_val;
      OP_POP:  result_o = XLEN'(pop_cnt);
      OP_CMPR: result_o = XLEN'(dec.alt ^ reg_eq);
      OP_CMPI: result_o = XLEN'(dec.alt ^ imm_eq);
      default: result_o = '0;
    endcase
  end

  assign valid_o = (dec.op != OP_NONE);
  assign dest_o  = dec.dest;
  assign wr_en_o = valid_o && (dec.dest != '0);
endmodule

// File: rtl/xiu_exec_chk.sv
module xiu_exec_chk (
  input logic [31:0] instr_i,
  input logic [63:0] src_a_i,
  input logic [63:0] src_b_i,
  input logic        valid_o,
  input logic [4:0]  dest_o,
  input logic        wr_en_o,
  input logic [63:0] result_o
);
  logic grp, is_badd, is_pop32, is_cmp;
  logic unused_ops;

  assign unused_ops = ^{src_a_i, src_b_i};
  assign grp      = (instr_i[31:26] == 6'b011100);
  assign is_badd  = grp && instr_i[10:0] == 11'b00000_101000;
  assign is_pop32 = grp && instr_i[20:16] == 5'd0 && instr_i[10:0] == 11'b00000_10110_0;
  assign is_cmp   = grp && ((instr_i[10:1] == 10'b00000_10101) || (instr_i[5:1] == 5'b10111));

  always_comb begin
    AST_FOREIGN_OPCODE: assert (grp || !valid_o);                              // R1
    AST_BYTE_RANGE: assert (!is_badd || result_o[63:8] == 56'd0);             // R2
    AST_POP32_RANGE: assert (!is_pop32 || result_o <= 64'd32);                // R7
    AST_CMP_BOOLEAN: assert (!is_cmp || result_o[63:1] == 63'd0);             // R8
    AST_NO_ZERO_DEST: assert (!wr_en_o || dest_o != 5'd0);                    // R10
    AST_IDLE_ZERO: assert (valid_o || (!wr_en_o && result_o == 64'd0));      // R12
  end
endmodule

bind xiu_exec xiu_exec_chk u_chk (
  .instr_i  (instr_i),
  .src_a_i  (src_a_i),
  .src_b_i  (src_b_i),
  .valid_o  (valid_o),
  .dest_o   (dest_o),
  .wr_en_o  (wr_en_o),
  .result_o (result_o)
);

// File: tb/sim_xiu_exec.sv
module sim_xiu_exec;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [63:0] a, b;
  logic        vld, wen;
  logic [4:0]  dst;
  logic [63:0] res;
  int          n_chk;
  int          n_err;
  bit          done;

  xiu_exec u0 (
    .instr_i  (instr),
    .src_a_i  (a),
    .src_b_i  (b),
    .valid_o  (vld),
    .dest_o   (dst),
    .wr_en_o  (wen),
    .result_o (res)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [4:0] sa,
                                        input logic [5:0] fn);
    return {6'b011100, rs, rt, rd, sa, fn};
  endfunction

  function automatic logic [31:0] enc_bf(input logic [4:0] rt, input int lenm1,
                                         input int p, input logic [4:0] sub);
    logic [5:0] p6;
    p6 = 6'(p);
    return {6'b011100, 5'd3, rt, 5'(lenm1), p6[4:0], sub, p6[5]};
  endfunction

  function automatic logic [31:0] enc_imm(input logic [4:0] rt, input logic [9:0] imm,
                                          input logic ne);
    return {6'b011100, 5'd4, rt, imm, 5'b10111, ne};
  endfunction

  function automatic logic [63:0] m_exts(input logic [63:0] v, input int p, input int l);
    logic [63:0] r;
    int top;
    logic s;
    top = p + l;
    if (top > 63) top = 63;
    s = v[top];
    for (int i = 0; i < 64; i++) r[i] = (p + i <= top) ? v[p + i] : s;
    return r;
  endfunction

  function automatic logic [63:0] m_cins(input logic [63:0] v, input int p, input int l);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = (i >= p && i - p <= l) ? v[i - p] : 1'b0;
    return r;
  endfunction

  function automatic logic [63:0] m_pop(input logic [63:0] v, input int nbits);
    int c;
    c = 0;
    for (int i = 0; i < nbits; i++) c += int'(v[i]);
    return 64'(c);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply a word after a rising edge, sample at the falling edge.
  task automatic run(input string tag, input logic [31:0] iw, input logic [63:0] va,
                     input logic [63:0] vb, input logic ev, input logic [4:0] ed,
                     input logic ew, input logic [63:0] er);
    @(posedge clk);
    instr = iw; a = va; b = vb;
    @(negedge clk);
    chk({tag, " valid"}, 64'(vld), 64'(ev));
    if (ev) chk({tag, " dest"}, 64'(dst), 64'(ed));
    chk({tag, " wr_en"}, 64'(wen), 64'(ew));
    chk({tag, " result"}, res, er);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 reset valid", 64'(vld), 64'd0);
    chk("R12 reset result", res, 64'd0);
  endtask

  task automatic t_badd;
    run("R2 byte add wrap", enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'b101000),
        64'hFF, 64'h02, 1, 5'd7, 1, 64'h01);
    run("R2 byte add high bits", enc_r(5'd1, 5'd2, 5'd9, 5'd0, 6'b101000),
        64'hDEAD_BEEF_0000_1280, 64'h1111_0000_FFFF_0034, 1, 5'd9, 1, 64'hB4);
  endtask

  task automatic t_mul;
    logic [63:0] x, y;
    x = 64'h1_0000_0001; y = 64'hFFFF_FFFF_FFFF_FFFF;
    run("R3 mul neg", enc_r(5'd1, 5'd2, 5'd4, 5'd0, 6'b000011), x, y, 1, 5'd4, 1, x * y);
    x = 64'h0123_4567_89AB_CDEF; y = 64'h0000_0000_0010_0001;
    run("R3 mul mix", enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'b000011), x, y, 1, 5'd5, 1, x * y);
  endtask

  task automatic t_exts;
    logic [63:0] v;
    v = 64'hF0E1_D2C3_B4A5_9687;
    run("R5 extract low", enc_bf(5'd6, 7, 4, 5'b11101), v, 0, 1, 5'd6, 1, m_exts(v, 4, 7));
    run("R5 extract pos", enc_bf(5'd6, 3, 0, 5'b11101), 64'h5, 0, 1, 5'd6, 1, 64'h5);
    run("R4 extract upper p=40", enc_bf(5'd8, 11, 40, 5'b11101), v, 0, 1, 5'd8, 1,
        m_exts(v, 40, 11));
    run("R11 extract overflow", enc_bf(5'd8, 20, 58, 5'b11101), v, 0, 1, 5'd8, 1,
        m_exts(v, 58, 20));
    run("R11 extract overflow pos", enc_bf(5'd8, 31, 60, 5'b11101), 64'h7000_0000_0000_0000,
        0, 1, 5'd8, 1, 64'h7);
  endtask

  task automatic t_cins;
    logic [63:0] v;
    v = 64'hFFFF_FFFF_ABCD_1234;
    run("R6 insert low", enc_bf(5'd9, 15, 8, 5'b11001), v, 0, 1, 5'd9, 1, m_cins(v, 8, 15));
    run("R4 insert upper p=33", enc_bf(5'd9, 31, 33, 5'b11001), v, 0, 1, 5'd9, 1,
        m_cins(v, 33, 31));
    run("R11 insert overflow", enc_bf(5'd9, 15, 56, 5'b11001), v, 0, 1, 5'd9, 1,
        64'h3400_0000_0000_0000);
  endtask

  task automatic t_pop;
    logic [63:0] v;
    v = 64'hFFFF_FFFF_FFFF_FFFF;
    run("R7 pop 32", enc_r(5'd1, 5'd0, 5'd3, 5'd0, 6'b101100), v, 0, 1, 5'd3, 1, 64'd32);
    run("R7 pop 64", enc_r(5'd1, 5'd0, 5'd3, 5'd0, 6'b101101), v, 0, 1, 5'd3, 1, 64'd64);
    v = 64'h8000_0001_7000_00F1;
    run("R7 pop 64 mix", enc_r(5'd1, 5'd0, 5'd3, 5'd0, 6'b101101), v, 0, 1, 5'd3, 1, m_pop(v, 64));
    run("R7 pop rt nonzero", enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b101101), v, 0, 0, 5'd0, 0, 64'd0);
  endtask

  task automatic t_cmp;
    run("R8 eq true", enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'b101010), 64'h55, 64'h55, 1, 5'd10, 1, 64'd1);
    run("R8 eq false", enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'b101010), 64'h55, 64'h54, 1, 5'd10, 1, 64'd0);
    run("R8 ne true", enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'b101011), 64'h55, 64'h54, 1, 5'd10, 1, 64'd1);
    run("R8 ne false", enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'b101011), 64'h9, 64'h9, 1, 5'd10, 1, 64'd0);
  endtask

  task automatic t_cmpi;
    run("R9 eq minus one", enc_imm(5'd11, 10'h3FF, 1'b0), 64'hFFFF_FFFF_FFFF_FFFF, 0,
        1, 5'd11, 1, 64'd1);
    run("R9 eq no zext", enc_imm(5'd11, 10'h3FF, 1'b0), 64'h3FF, 0, 1, 5'd11, 1, 64'd0);
    run("R9 ne", enc_imm(5'd11, 10'd5, 1'b1), 64'd6, 0, 1, 5'd11, 1, 64'd1);
    run("R9 ne equal", enc_imm(5'd11, 10'd5, 1'b1), 64'd5, 0, 1, 5'd11, 1, 64'd0);
  endtask

  task automatic t_dest0;
    run("R10 rd zero", enc_r(5'd1, 5'd2, 5'd0, 5'd0, 6'b101000), 64'h1, 64'h1, 1, 5'd0, 0, 64'h2);
    run("R10 rt zero imm", enc_imm(5'd0, 10'd0, 1'b0), 64'd0, 0, 1, 5'd0, 0, 64'd1);
  endtask

  task automatic t_unmatched;
    run("R1 foreign opcode", {6'b011101, 26'h0000_0A8}, 64'hFF, 64'h2, 0, 5'd0, 0, 64'd0);
    run("R12 unknown function", enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'b111111), 64'h1, 64'h2, 0, 5'd0, 0, 64'd0);
    run("R12 byte add shamt", enc_r(5'd1, 5'd2, 5'd3, 5'd4, 6'b101000), 64'h1, 64'h2, 0, 5'd0, 0, 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    instr = '0; a = '0; b = '0;
    rst_n = 1'b0;
    t_reset();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_badd();
    t_mul();
    t_exts();
    t_cins();
    t_pop();
    t_cmp();
    t_cmpi();
    t_dest0();
    t_unmatched();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule